// File: doc/BRIEF.md
# String Primitive Sequencer

This block runs one string primitive from start to finish against a synchronous memory port. The caller supplies the primitive (move, load, store, compare or scan), the element width (byte or word), a repeat mode (none, unconditional repeat, repeat while equal, repeat while not equal), a direction bit, and the starting values of the source and destination offsets, the count, both segment bases and the accumulator. After a one-cycle `start` the sequencer walks the elements. It issues one memory access per element read or write, and each access waits for an acknowledge. When the sequence ends it pulses `done`. At that point the updated offsets, count, accumulator and the six compare flags are on its outputs.

A physical address is the 16-bit segment shifted left by four plus the 16-bit offset, truncated to 20 bits. Every access carries the whole element. A word uses both byte lanes (enable `11`). A byte uses only the low lane `[7:0]` (enable `01`), and the high lane of write data is zero.

The controller is one state machine with these states:
- ST_IDLE: waits for `start`.
- ST_CHECK: applies the count test before each element.
- ST_RD_SRC: reads the source element.
- ST_RD_DST: reads the destination element.
- ST_WR_DST: writes the destination element.
- ST_STEP: advances the pointers and count, latches the flags and decides the exit.
- ST_DONE: one cycle that produces `done`.

The transitions are:
- ST_IDLE→ST_CHECK when `start` is high.
- ST_CHECK→ST_DONE when a repeat mode is set and the count is zero.
- ST_CHECK→ST_RD_SRC for move, load and compare.
- ST_CHECK→ST_WR_DST for store.
- ST_CHECK→ST_RD_DST for scan.
- ST_RD_SRC→ST_WR_DST (move), ST_RD_DST (compare) or ST_STEP (load), on acknowledge.
- ST_RD_DST→ST_STEP and ST_WR_DST→ST_STEP, on acknowledge.
- ST_STEP→ST_CHECK to continue, or ST_STEP→ST_DONE to stop.
- ST_DONE→ST_IDLE.

Top module: `strop_engine`

## Requirements
- R1: With any repeat mode and an initial count of zero, the block ends with no memory access, and offsets, count, accumulator and flags (all zero) are left unchanged.
- R2: Under a repeat mode, the count drops by exactly one after each element. Unconditional repeat processes exactly the initial count of elements and ends with a count of zero.
- R3: For compare and scan, repeat-while-equal (rep_sel=2) stops after the first element whose result clears the zero flag. Repeat-while-not-equal (rep_sel=3) stops after the first element that sets it. For move, load and store, both modes behave like unconditional repeat.
- R4: After each element, the offsets that the primitive uses step by 1 (byte) or 2 (word). They go up when `dir_dn`=0 and down when it is 1, and they wrap modulo 2^16.
- R5: Compare (op_sel=3) computes source element minus destination element and advances both offsets. `flags_out` bit order is {OF,SF,ZF,AF,PF,CF} from bit 5 to bit 0: CF is the borrow out of the element width, AF the borrow out of bit 3, PF is 1 for an even number of ones in the low result byte, and OF the signed overflow. Flags are cleared at start and only compare and scan write them.
- R6: Scan (op_sel=4) computes accumulator (low byte for byte width) minus the destination element, sets the same flags, and advances only the destination offset.
- R7: Move (op_sel=0) copies the source element to the destination and advances both offsets. Load (op_sel=1) puts the source element in the accumulator and advances only the source offset; a byte load changes only bits [7:0]. Store (op_sel=2) writes the accumulator to the destination and advances only the destination offset. Byte accesses use lane [7:0] with enable 01. Word accesses carry the low-address byte in [7:0] and use enable 11.
- R8: The source address is DS*16+SI and the destination address ES*16+DI, both modulo 2^20. A request keeps address, write flag and data stable until the cycle in which it is acknowledged.
- R9: With rep_sel=0 exactly one element is processed and the count is unchanged. `busy` is high from the cycle after `start` until `done`, and `done` lasts one cycle.
- R10: After reset `busy`, `done` and `mem_req` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken in idle) |
| op_sel | input | 3 | 0 move, 1 load, 2 store, 3 compare, 4 scan |
| wide_sel | input | 1 | 1 word element, 0 byte element |
| rep_sel | input | 2 | 0 none, 1 repeat, 2 while equal, 3 while not equal |
| dir_dn | input | 1 | 1 steps offsets downward |
| si_in | input | 16 | Initial source offset |
| di_in | input | 16 | Initial destination offset |
| cx_in | input | 16 | Initial count |
| ds_in | input | 16 | Source segment |
| es_in | input | 16 | Destination segment |
| acc_in | input | 16 | Initial accumulator |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Physical address |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end strobe |
| si_out | output | 16 | Current source offset |
| di_out | output | 16 | Current destination offset |
| cx_out | output | 16 | Current count |
| acc_out | output | 16 | Current accumulator |
| flags_out | output | 6 | {OF,SF,ZF,AF,PF,CF} |

## Verification
The bench attacks several corner cases:
- A zero count under both an unconditional and a conditional repeat. A design that did the element before testing the count would make an access and wrap the count to FFFFh.
- Compare and scan runs where the mismatch or match sits mid-string, and a run that ends on its first element. An inverted or missing zero-flag exit would run to the full count, or stop one element late.
- A repeat-while-equal move. A design that applied the zero-flag exit there would stop after one element.
- Offsets stepped downward through zero and upward through FFFFh, and a byte load over a nonzero high accumulator byte. These catch missing wrap, a wrong step size or a clobbered upper byte.
- Acknowledge delays that vary, used to expose a request that drops or changes address before it is acknowledged.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_CMP   = 3'd3,
        OP_SCAN  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RP_NONE     = 2'd0,
        RP_ALL      = 2'd1,
        RP_WHILE_EQ = 2'd2,
        RP_WHILE_NE = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_DST,
        ST_STEP,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

endpackage

// File: rtl/strop_agen.sv
module strop_agen #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PADDR_W   = 20
) (
    input  logic [SEG_W-1:0]   seg,
    input  logic [OFF_W-1:0]   off,
    output logic [PADDR_W-1:0] paddr
);
    localparam int SUM_W = SEG_W + SEG_SHIFT + 1;

    logic [SUM_W-1:0] sum;

    // segment base plus offset, upper bits dropped
    assign sum   = {1'b0, seg, {SEG_SHIFT{1'b0}}} + SUM_W'(off);
    assign paddr = sum[PADDR_W-1:0];

endmodule

// File: rtl/strop_flags.sv
module strop_flags
    import strop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              wide,
    output flags_t            flags
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] diff_w;
    logic [HALF_W:0] diff_b;
    logic [4:0]      diff_n;

    assign diff_w = {1'b0, lhs} - {1'b0, rhs};
    assign diff_b = {1'b0, lhs[HALF_W-1:0]} - {1'b0, rhs[HALF_W-1:0]};
    assign diff_n = {1'b0, lhs[3:0]} - {1'b0, rhs[3:0]};

    always_comb begin
        flags.af = diff_n[4];
        flags.pf = ~^diff_w[7:0];
        if (wide) begin
            flags.cf = diff_w[DATA_W];
            flags.zf = (diff_w[DATA_W-1:0] == '0);
            flags.sf = diff_w[DATA_W-1];
            flags.of = (lhs[DATA_W-1] ^ rhs[DATA_W-1]) & (lhs[DATA_W-1] ^ diff_w[DATA_W-1]);
        end else begin
            flags.cf = diff_b[HALF_W];
            flags.zf = (diff_b[HALF_W-1:0] == '0);
            flags.sf = diff_b[HALF_W-1];
            flags.of = (lhs[HALF_W-1] ^ rhs[HALF_W-1]) & (lhs[HALF_W-1] ^ diff_b[HALF_W-1]);
        end
    end

endmodule

// File: rtl/strop_engine.sv
module strop_engine
    import strop_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PADDR_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op_sel,
    input  logic               wide_sel,
    input  logic [1:0]         rep_sel,
    input  logic               dir_dn,
    input  logic [DATA_W-1:0]  si_in,
    input  logic [DATA_W-1:0]  di_in,
    input  logic [DATA_W-1:0]  cx_in,
    input  logic [DATA_W-1:0]  ds_in,
    input  logic [DATA_W-1:0]  es_in,
    input  logic [DATA_W-1:0]  acc_in,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [1:0]         mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  si_out,
    output logic [DATA_W-1:0]  di_out,
    output logic [DATA_W-1:0]  cx_out,
    output logic [DATA_W-1:0]  acc_out,
    output logic [5:0]         flags_out
);
    localparam int          HALF_W   = DATA_W / 2;
    localparam int          N_PTR    = 2;
    localparam [DATA_W-1:0] STEP_ONE = DATA_W'(1);
    localparam [DATA_W-1:0] STEP_TWO = DATA_W'(2);

    st_e               state_q, state_d;
    op_e               op_q;
    rep_e              rep_q;
    logic              wide_q, df_q;
    logic [DATA_W-1:0] si_q, di_q, cx_q, ds_q, es_q, acc_q;
    logic [DATA_W-1:0] src_q, dst_q;
    flags_t            flags_q, flags_new;

    // address generation: index 0 source, index 1 destination
    logic [DATA_W-1:0]  seg_v [N_PTR];
    logic [DATA_W-1:0]  off_v [N_PTR];
    logic [PADDR_W-1:0] pa_v  [N_PTR];

    assign seg_v[0] = ds_q;
    assign off_v[0] = si_q;
    assign seg_v[1] = es_q;
    assign off_v[1] = di_q;

    for (genvar g = 0; g < N_PTR; g++) begin : g_agen
        strop_agen #(
            .SEG_W    (DATA_W),
            .OFF_W    (DATA_W),
            .SEG_SHIFT(SEG_SHIFT),
            .PADDR_W  (PADDR_W)
        ) u_agen (
            .seg  (seg_v[g]),
            .off  (off_v[g]),
            .paddr(pa_v[g])
        );
    end

    // compare datapath
    logic              is_cmp;
    logic [DATA_W-1:0] cmp_lhs;

    assign is_cmp  = (op_q == OP_CMP) || (op_q == OP_SCAN);
    assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : src_q;

    strop_flags #(.DATA_W(DATA_W)) u_flags (
        .lhs  (cmp_lhs),
        .rhs  (dst_q),
        .wide (wide_q),
        .flags(flags_new)
    );

    // per-element updates
    logic [DATA_W-1:0] step, si_nxt, di_nxt, cx_nxt, rd_fit;
    logic              moves_si, moves_di, stop;

    assign step     = wide_q ? STEP_TWO : STEP_ONE;
    assign moves_si = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
    assign moves_di = (op_q != OP_LOAD);
    assign si_nxt   = moves_si ? (df_q ? si_q - step : si_q + step) : si_q;
    assign di_nxt   = moves_di ? (df_q ? di_q - step : di_q + step) : di_q;
    assign cx_nxt   = (rep_q != RP_NONE) ? cx_q - STEP_ONE : cx_q;
    assign rd_fit   = wide_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};

    assign stop = (rep_q == RP_NONE) || (cx_nxt == '0)
               || (is_cmp && rep_q == RP_WHILE_EQ && !flags_new.zf)
               || (is_cmp && rep_q == RP_WHILE_NE &&  flags_new.zf);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (rep_q != RP_NONE && cx_q == '0)           state_d = ST_DONE;
                else if (op_q == OP_STORE)                    state_d = ST_WR_DST;
                else if (op_q == OP_SCAN)                     state_d = ST_RD_DST;
                else                                          state_d = ST_RD_SRC;
            end
            ST_RD_SRC: if (mem_ack) begin
                if (op_q == OP_MOVE)      state_d = ST_WR_DST;
                else if (op_q == OP_CMP)  state_d = ST_RD_DST;
                else                      state_d = ST_STEP;
            end
            ST_RD_DST: if (mem_ack) state_d = ST_STEP;
            ST_WR_DST: if (mem_ack) state_d = ST_STEP;
            ST_STEP:   state_d = stop ? ST_DONE : ST_CHECK;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_MOVE;
            rep_q   <= RP_NONE;
            wide_q  <= 1'b0;
            df_q    <= 1'b0;
            si_q    <= '0;
            di_q    <= '0;
            cx_q    <= '0;
            ds_q    <= '0;
            es_q    <= '0;
            acc_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    op_q    <= op_e'(op_sel);
                    rep_q   <= rep_e'(rep_sel);
                    wide_q  <= wide_sel;
                    df_q    <= dir_dn;
                    si_q    <= si_in;
                    di_q    <= di_in;
                    cx_q    <= cx_in;
                    ds_q    <= ds_in;
                    es_q    <= es_in;
                    acc_q   <= acc_in;
                    flags_q <= '0;
                end
                ST_RD_SRC: if (mem_ack) begin
                    if (op_q == OP_LOAD) begin
                        if (wide_q) acc_q <= mem_rdata;
                        else        acc_q <= {acc_q[DATA_W-1:HALF_W], mem_rdata[HALF_W-1:0]};
                    end else begin
                        src_q <= rd_fit;
                    end
                end
                ST_RD_DST: if (mem_ack) dst_q <= rd_fit;
                ST_STEP: begin
                    si_q <= si_nxt;
                    di_q <= di_nxt;
                    cx_q <= cx_nxt;
                    if (is_cmp) flags_q <= flags_new;
                end
                default: ;
            endcase
        end
    end

    // outputs
    logic [DATA_W-1:0] wr_val;

    always_comb begin
        wr_val    = (op_q == OP_MOVE) ? src_q : acc_q;
        mem_req   = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST) || (state_q == ST_WR_DST);
        mem_we    = (state_q == ST_WR_DST);
        mem_addr  = (state_q == ST_RD_SRC) ? pa_v[0] : pa_v[1];
        mem_be    = wide_q ? 2'b11 : 2'b01;
        mem_wdata = wide_q ? wr_val : {{HALF_W{1'b0}}, wr_val[HALF_W-1:0]};
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        si_out    = si_q;
        di_out    = di_q;
        cx_out    = cx_q;
        acc_out   = acc_q;
        flags_out = flags_q;
    end

    // assertions
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_zero_cx_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && rep_q != RP_NONE && cx_q == '0) |=> (done && !mem_req));

    p_cx_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && rep_q != RP_NONE) |=> (cx_out == $past(cx_out) - STEP_ONE));

    p_norep_cx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && rep_q == RP_NONE) |=> $stable(cx_out));

    p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !wide_q) |-> (mem_be == 2'b01 && mem_wdata[DATA_W-1:HALF_W] == '0));

    p_scan_si_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && op_q == OP_SCAN) |=> $stable(si_out));

endmodule

// File: tb/strop_engine_bench.sv
module strop_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 16;
    localparam logic [15:0] DSEG = 16'h0010;
    localparam logic [15:0] ESEG = 16'h0020;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic [1:0]  rep;
        logic        df;
        logic [15:0] si;
        logic [15:0] di;
        logic [15:0] cx;
        logic [15:0] acc;
        logic [15:0] exp_cx;
    } vec_t;

    // op, wide, rep, df, si, di, cx, acc, expected final count
    localparam vec_t VECS [0:NV-1] = '{
        {3'd0, 1'b0, 2'd1, 1'b0, 16'h0000, 16'h0010, 16'd4,  16'h0000, 16'd0},
        {3'd0, 1'b1, 2'd1, 1'b1, 16'h0020, 16'h0040, 16'd3,  16'h0000, 16'd0},
        {3'd1, 1'b0, 2'd0, 1'b0, 16'h0003, 16'h0000, 16'd7,  16'hAB00, 16'd7},
        {3'd1, 1'b1, 2'd1, 1'b0, 16'h0000, 16'h0000, 16'd2,  16'h0000, 16'd0},
        {3'd2, 1'b0, 2'd1, 1'b0, 16'h0000, 16'h0030, 16'd5,  16'h1234, 16'd0},
        {3'd2, 1'b1, 2'd0, 1'b1, 16'h0000, 16'h0050, 16'd9,  16'hBEEF, 16'd9},
        {3'd3, 1'b0, 2'd2, 1'b0, 16'h0000, 16'h0000, 16'd10, 16'h0000, 16'd4},
        {3'd3, 1'b0, 2'd3, 1'b0, 16'h0000, 16'h0000, 16'd10, 16'h0000, 16'd9},
        {3'd4, 1'b0, 2'd3, 1'b0, 16'h0000, 16'h0000, 16'd20, 16'h5507, 16'd12},
        {3'd4, 1'b1, 2'd2, 1'b0, 16'h0000, 16'h0000, 16'd5,  16'h0100, 16'd3},
        {3'd0, 1'b0, 2'd1, 1'b0, 16'h0004, 16'h0008, 16'd0,  16'h0000, 16'd0},
        {3'd3, 1'b1, 2'd2, 1'b0, 16'h0004, 16'h0008, 16'd0,  16'h0000, 16'd0},
        {3'd0, 1'b0, 2'd2, 1'b0, 16'h0010, 16'h0060, 16'd3,  16'h0000, 16'd0},
        {3'd1, 1'b1, 2'd1, 1'b1, 16'h0000, 16'h0000, 16'd2,  16'h0000, 16'd0},
        {3'd2, 1'b0, 2'd1, 1'b0, 16'h0000, 16'hFFFF, 16'd2,  16'h00C3, 16'd0},
        {3'd4, 1'b0, 2'd0, 1'b0, 16'h0000, 16'h0002, 16'd3,  16'h0009, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  op_sel;
    logic        wide_sel;
    logic [1:0]  rep_sel;
    logic        dir_dn;
    logic [15:0] si_in, di_in, cx_in, ds_in, es_in, acc_in;
    logic        mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] si_out, di_out, cx_out, acc_out;
    logic [5:0]  flags_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    strop_engine u_strop_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_sel(op_sel), .wide_sel(wide_sel), .rep_sel(rep_sel), .dir_dn(dir_dn),
        .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .ds_in(ds_in), .es_in(es_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .si_out(si_out), .di_out(di_out), .cx_out(cx_out),
        .acc_out(acc_out), .flags_out(flags_out)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mem     [0:1023];
    logic [7:0] ref_mem [0:1023];
    logic [9:0] ai;
    int         n_acc   = 0;
    int         wait_cnt = 0;
    int         lat_sel  = 0;
    logic       cur_wide = 1'b0;
    int         be_err   = 0;
    int         hold_err = 0;
    logic       prev_req = 1'b0, prev_ack = 1'b0, prev_we = 1'b0;
    logic [19:0] prev_addr = '0;
    logic [15:0] prev_wd = '0;

    assign ai = mem_addr[9:0];

    // memory responder with varying latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            mem_rdata <= '0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat_sel) begin
                mem_ack   <= 1'b1;
                wait_cnt  <= 0;
                n_acc     <= n_acc + 1;
                lat_sel   <= (lat_sel == 2) ? 0 : lat_sel + 1;
                mem_rdata <= {mem[ai + 10'd1], mem[ai]};
                if (mem_we) begin
                    mem[ai] <= mem_wdata[7:0];
                    if (mem_be[1]) mem[ai + 10'd1] <= mem_wdata[15:8];
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // port monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_be != (cur_wide ? 2'b11 : 2'b01)) be_err = be_err + 1;
            if (prev_req && !prev_ack &&
                (!mem_req || mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wd))
                hold_err = hold_err + 1;
        end
        prev_req  = mem_req;
        prev_ack  = mem_ack;
        prev_addr = mem_addr;
        prev_we   = mem_we;
        prev_wd   = mem_wdata;
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // independent reference model
    function automatic logic [9:0] ref_idx(input logic [15:0] seg, input logic [15:0] off);
        logic [19:0] pa;
        pa = {seg, 4'h0} + {4'h0, off};
        return pa[9:0];
    endfunction

    function automatic logic [15:0] ref_rd(input logic [15:0] seg, input logic [15:0] off, input logic w);
        logic [9:0] i;
        i = ref_idx(seg, off);
        return w ? {ref_mem[i + 10'd1], ref_mem[i]} : {8'h00, ref_mem[i]};
    endfunction

    task automatic ref_wr(input logic [15:0] seg, input logic [15:0] off, input logic [15:0] d, input logic w);
        logic [9:0] i;
        i = ref_idx(seg, off);
        ref_mem[i] = d[7:0];
        if (w) ref_mem[i + 10'd1] = d[15:8];
    endtask

    function automatic logic [5:0] ref_flags(input logic [15:0] a, input logic [15:0] b, input logic w);
        int sa, sb, d;
        logic [15:0] r;
        logic of, sf, zf, af, pf, cf;
        if (w) begin
            sa = int'($signed(a)); sb = int'($signed(b)); d = sa - sb;
            of = (d > 32767) || (d < -32768);
            r  = a - b;
            cf = (a < b);
            sf = r[15];
            zf = (r == 16'h0);
        end else begin
            sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0])); d = sa - sb;
            of = (d > 127) || (d < -128);
            r  = {8'h00, a[7:0] - b[7:0]};
            cf = (a[7:0] < b[7:0]);
            sf = r[7];
            zf = (r[7:0] == 8'h0);
        end
        af = (a[3:0] < b[3:0]);
        pf = ~^r[7:0];
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic ref_run(input vec_t v, output logic [15:0] rsi, output logic [15:0] rdi,
                           output logic [15:0] rcx, output logic [15:0] racc,
                           output logic [5:0] rfl, output int rn);
        logic [15:0] stp, e;
        rsi = v.si; rdi = v.di; rcx = v.cx; racc = v.acc; rfl = '0; rn = 0;
        stp = v.wide ? 16'd2 : 16'd1;
        forever begin
            if (v.rep != 2'd0 && rcx == 16'd0) break;
            case (v.op)
                3'd0: begin
                    e = ref_rd(DSEG, rsi, v.wide); ref_wr(ESEG, rdi, e, v.wide); rn += 2;
                    rsi = v.df ? rsi - stp : rsi + stp; rdi = v.df ? rdi - stp : rdi + stp;
                end
                3'd1: begin
                    e = ref_rd(DSEG, rsi, v.wide); rn += 1;
                    if (v.wide) racc = e; else racc[7:0] = e[7:0];
                    rsi = v.df ? rsi - stp : rsi + stp;
                end
                3'd2: begin
                    ref_wr(ESEG, rdi, racc, v.wide); rn += 1;
                    rdi = v.df ? rdi - stp : rdi + stp;
                end
                3'd3: begin
                    rfl = ref_flags(ref_rd(DSEG, rsi, v.wide), ref_rd(ESEG, rdi, v.wide), v.wide); rn += 2;
                    rsi = v.df ? rsi - stp : rsi + stp; rdi = v.df ? rdi - stp : rdi + stp;
                end
                default: begin
                    rfl = ref_flags(racc, ref_rd(ESEG, rdi, v.wide), v.wide); rn += 1;
                    rdi = v.df ? rdi - stp : rdi + stp;
                end
            endcase
            if (v.rep == 2'd0) break;
            rcx = rcx - 16'd1;
            if (rcx == 16'd0) break;
            if (v.op >= 3'd3 && v.rep == 2'd2 && !rfl[3]) break;
            if (v.op >= 3'd3 && v.rep == 2'd3 &&  rfl[3]) break;
        end
    endtask

    task automatic init_mem();
        for (int a = 0; a < 1024; a++) begin
            mem[a]     = a[7:0];
            ref_mem[a] = a[7:0];
        end
        mem[10'h205]     = 8'hEE;
        ref_mem[10'h205] = 8'hEE;
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        logic [15:0] esi, edi, ecx, eacc;
        logic [5:0]  efl;
        int          en, acc0, cyc, bad;
        string       ptag, ftag, ctag;
        init_mem();
        ref_run(v, esi, edi, ecx, eacc, efl, en);
        ptag = (v.op == 3'd3) ? "R5" : (v.op == 3'd4) ? "R6" : "R4";
        ftag = (v.op == 3'd4) ? "R6" : "R5";
        ctag = (v.rep == 2'd0) ? "R9" : (v.rep >= 2'd2) ? "R3" : "R2";
        @(negedge clk);
        cur_wide = v.wide;
        op_sel = v.op; wide_sel = v.wide; rep_sel = v.rep; dir_dn = v.df;
        si_in = v.si; di_in = v.di; cx_in = v.cx; acc_in = v.acc;
        ds_in = DSEG; es_in = ESEG;
        acc0 = n_acc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", $sformatf("v%0d busy after start", idx), busy, 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R9", $sformatf("v%0d done seen", idx), done, 1);
        chk(cx_out == v.exp_cx, ctag, $sformatf("v%0d count", idx), cx_out, v.exp_cx);
        chk(cx_out == ecx, ctag, $sformatf("v%0d count model", idx), cx_out, ecx);
        chk(si_out == esi, ptag, $sformatf("v%0d source offset", idx), si_out, esi);
        chk(di_out == edi, ptag, $sformatf("v%0d dest offset", idx), di_out, edi);
        chk(acc_out == eacc, "R7", $sformatf("v%0d accumulator", idx), acc_out, eacc);
        chk(flags_out == efl, ftag, $sformatf("v%0d flags", idx), flags_out, efl);
        chk((n_acc - acc0) == en, (v.cx == 16'd0) ? "R1" : "R8",
            $sformatf("v%0d access count", idx), n_acc - acc0, en);
        bad = 0;
        for (int a = 0; a < 1024; a++) if (mem[a] !== ref_mem[a]) bad++;
        chk(bad == 0, "R7", $sformatf("v%0d memory image mismatches", idx), bad, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", $sformatf("v%0d done one cycle", idx), {done, busy}, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        op_sel = '0; wide_sel = 1'b0; rep_sel = '0; dir_dn = 1'b0;
        si_in = '0; di_in = '0; cx_in = '0; ds_in = '0; es_in = '0; acc_in = '0;
        init_mem();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R10", "control outputs in reset", {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(si_out == 0 && di_out == 0 && cx_out == 0 && acc_out == 0 && flags_out == 0,
            "R10", "result outputs after reset", {si_out, cx_out}, 0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        chk(hold_err == 0, "R8", "request dropped or changed before acknowledge", hold_err, 0);
        chk(be_err == 0, "R7", "byte enables against width", be_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule